// File: doc/BRIEF.md
# Buffered 16-bit Compare Channel

This block is one compare channel of a timer. An 8-bit CPU bus loads a 16-bit compare value in two byte writes. The high byte is written first and only lands in a shared holding byte. The low-byte write then places the holding byte and the new low byte into the target register together, in one clock edge.

The `buffered` input follows the waveform mode: it is high in PWM modes and low in the plain counting and clear-on-match modes. When it is high, CPU writes land in a shadow register. The shadow value moves into the active compare register only on the counter event chosen by `commit_sel`, so a PWM period never changes halfway through. When it is low, writes go straight into the active register.

A full-width equality comparator runs against the external count. It drives a single-cycle strobe for the downstream waveform logic and a sticky match flag.

Top module: `ocu_dbuf`

## Requirements
- R1: After reset, the holding byte, the shadow register, the active register and the match flag are all zero.
- R2: A high-byte write (`bus_we`=1, `bus_hi`=1) loads only the holding byte. It changes neither `cmp_active` nor the value read back.
- R3: A low-byte write (`bus_we`=1, `bus_hi`=0) commits {holding byte, `bus_wdata`} in that edge. If several high-byte writes come first, the most recent one is used.
- R4: With `buffered`=0, a low-byte write updates the active register and the shadow register with the same word.
- R5: With `buffered`=1, a low-byte write updates only the shadow register. `cmp_active` keeps its value until a commit.
- R6: With `buffered`=1, the shadow value is copied into the active register at an edge where (`commit_sel[0]` and `at_top`) or (`commit_sel[1]` and `at_bottom`). A low-byte write in that same edge goes to the shadow register, and the previous shadow value is the one committed. No commit happens with `buffered`=0.
- R7: `bus_rdata` is combinational. It returns the high byte when `bus_rd_hi`=1 and the low byte otherwise, taken from the shadow register when `buffered`=1 and from the active register when `buffered`=0.
- R8: `match_pulse` is high in exactly the cycles where all bits of `count` equal `cmp_active`.
- R9: `match_flag` sets on the edge after a cycle with `match_pulse`. It clears on an edge where `flag_clr` or `irq_ack` is high and there is no match. A match in the same cycle as a clear keeps the flag set.
- R10: `cmp_active` always shows the active compare register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Byte write strobe |
| bus_hi | input | 1 | Write byte select: 1 high, 0 low |
| bus_wdata | input | BW | Write data byte |
| bus_rd_hi | input | 1 | Read byte select: 1 high, 0 low |
| bus_rdata | output | BW | Read data byte |
| buffered | input | 1 | Double buffering enable (PWM mode) |
| commit_sel | input | 2 | Bit 0: commit at TOP; bit 1: commit at BOTTOM |
| count | input | 2*BW | Counter value |
| at_top | input | 1 | Counter is at TOP this cycle |
| at_bottom | input | 1 | Counter is at BOTTOM this cycle |
| flag_clr | input | 1 | CPU write-one-to-clear of the match flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| match_pulse | output | 1 | Single-cycle match strobe |
| match_flag | output | 1 | Sticky match flag |
| cmp_active | output | 2*BW | Active compare value |

## Verification
The bench builds the block with the default BW=8, so the compare word is 16 bits wide and a mismatch in any one of the upper or lower eight bits can be seen at the comparator. Random counts are steered toward the active value about a quarter of the time. This makes matches frequent enough that they coincide with clears, acknowledges, commits and same-edge low-byte writes. Random commit events against random `commit_sel` values reach each commit source alone, both together, and commits blocked while unbuffered.

// File: rtl/ocu_dbuf.sv
module ocu_dbuf #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_hi,
  input  logic [BW-1:0] bus_wdata,
  input  logic          bus_rd_hi,
  output logic [BW-1:0] bus_rdata,
  input  logic          buffered,
  input  logic [1:0]    commit_sel,
  input  logic [CW-1:0] count,
  input  logic          at_top,
  input  logic          at_bottom,
  input  logic          flag_clr,
  input  logic          irq_ack,
  output logic          match_pulse,
  output logic          match_flag,
  output logic [CW-1:0] cmp_active
);

  logic [BW-1:0] hold_hi;
  logic [CW-1:0] shadow, active;
  logic          lo_wr, commit_now;
  logic [CW-1:0] view;

  assign lo_wr      = bus_we && !bus_hi;
  assign commit_now = buffered && ((commit_sel[0] && at_top) || (commit_sel[1] && at_bottom));
  assign view       = buffered ? shadow : active;
  assign bus_rdata  = bus_rd_hi ? view[CW-1:BW] : view[BW-1:0];
  assign match_pulse = (count == active);
  assign cmp_active  = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_hi <= '0;
      shadow  <= '0;
      active  <= '0;
    end else begin
      if (bus_we && bus_hi) hold_hi <= bus_wdata;
      if (lo_wr) shadow <= {hold_hi, bus_wdata};
      if (commit_now)
        active <= shadow;
      else if (lo_wr && !buffered)
        active <= {hold_hi, bus_wdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) match_flag <= 1'b0;
    else if (match_pulse) match_flag <= 1'b1;
    else if (flag_clr || irq_ack) match_flag <= 1'b0;
  end

  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> match_flag);
  a_r9_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr || irq_ack) && !match_pulse) |=> !match_flag);
  a_r2_hi_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!buffered && bus_we && bus_hi) |=> $stable(cmp_active));
  a_r4_direct_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!buffered && bus_we && !bus_hi) |=> (cmp_active[BW-1:0] == $past(bus_wdata)));
  a_r5_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !(commit_sel[0] && at_top) && !(commit_sel[1] && at_bottom))
      |=> $stable(cmp_active));

endmodule

// File: tb/ocu_dbuf_tb.sv
module ocu_dbuf_tb;
  localparam int PERIOD = 10;
  localparam int BW = 8;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic bus_we = 0, bus_hi = 0, bus_rd_hi = 0, buffered = 0;
  logic [BW-1:0] bus_wdata = '0;
  logic [1:0] commit_sel = 2'b00;
  logic [CW-1:0] count = '0;
  logic at_top = 0, at_bottom = 0, flag_clr = 0, irq_ack = 0;
  logic [BW-1:0] bus_rdata;
  logic match_pulse, match_flag;
  logic [CW-1:0] cmp_active;

  int vectors = 0, fails = 0;
  bit finished = 0;
  logic [BW-1:0] m_hold;
  logic [CW-1:0] m_shadow, m_active;
  logic m_flag;

  ocu_dbuf #(.BW(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_hi(bus_hi), .bus_wdata(bus_wdata),
    .bus_rd_hi(bus_rd_hi), .bus_rdata(bus_rdata), .buffered(buffered), .commit_sel(commit_sel),
    .count(count), .at_top(at_top), .at_bottom(at_bottom), .flag_clr(flag_clr),
    .irq_ack(irq_ack), .match_pulse(match_pulse), .match_flag(match_flag), .cmp_active(cmp_active));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [BW-1:0] exp_rd();
    logic [CW-1:0] v = buffered ? m_shadow : m_active;
    return bus_rd_hi ? v[CW-1:BW] : v[BW-1:0];
  endfunction

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R10 R6 active compare value", cmp_active, m_active);
    chk("R9 match flag", {15'd0, match_flag}, {15'd0, m_flag});
    chk("R7 read data", {8'd0, bus_rdata}, {8'd0, exp_rd()});
    chk("R8 match strobe", {15'd0, match_pulse}, {15'd0, (count == m_active)});
  endtask

  task automatic cyc();
    logic [CW-1:0] nsh = m_shadow, nact = m_active;
    logic [BW-1:0] nh = m_hold;
    logic commit;
    commit = buffered && ((commit_sel[0] && at_top) || (commit_sel[1] && at_bottom));
    if (bus_we && bus_hi) nh = bus_wdata;
    if (bus_we && !bus_hi) begin
      nsh = {m_hold, bus_wdata};
      if (!buffered) nact = {m_hold, bus_wdata};
    end
    if (commit) nact = m_shadow;
    m_flag = (count == m_active) ? 1'b1 : ((flag_clr || irq_ack) ? 1'b0 : m_flag);
    @(posedge clk);
    m_hold = nh; m_shadow = nsh; m_active = nact;
    #1;
    compare_all();
    @(negedge clk);
    bus_we = 0; flag_clr = 0; irq_ack = 0; at_top = 0; at_bottom = 0;
  endtask

  task automatic wr(input logic hi, input logic [7:0] d);
    bus_we = 1; bus_hi = hi; bus_wdata = d; cyc();
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_hold = '0; m_shadow = '0; m_active = '0; m_flag = 0;
    count = 16'hFFFF;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1 reset active", cmp_active, 16'h0);
    chk("R1 reset flag", {15'd0, match_flag}, 16'h0);
    chk("R1 reset read", {8'd0, bus_rdata}, 16'h0);
    @(negedge clk);
    // R2 and R3: last high byte wins, high writes do not touch active
    wr(1, 8'h12);
    chk("R2 hi write leaves active", cmp_active, 16'h0);
    wr(1, 8'h34);
    wr(0, 8'h56);
    chk("R3 R4 direct commit", cmp_active, 16'h3456);
    // R5: buffered write goes to shadow, read shows shadow
    buffered = 1; commit_sel = 2'b01;
    wr(1, 8'hAB); wr(0, 8'hCD);
    chk("R5 active held", cmp_active, 16'h3456);
    bus_rd_hi = 1; #1;
    chk("R7 read shadow hi", {8'd0, bus_rdata}, 16'h00AB);
    // R6: bottom ignored when only top selected, then top commits
    at_bottom = 1; cyc();
    chk("R6 no commit at bottom", cmp_active, 16'h3456);
    at_top = 1; cyc();
    chk("R6 commit at top", cmp_active, 16'hABCD);
    // R9: match with clear keeps flag, clear alone clears, ack clears
    count = 16'hABCD; flag_clr = 1; cyc();
    count = 16'h0000; cyc();
    chk("R9 match beats clear", {15'd0, match_flag}, 16'h1);
    flag_clr = 1; cyc();
    chk("R9 clear", {15'd0, match_flag}, 16'h0);
    count = 16'hABCD; cyc(); count = 16'h0; irq_ack = 1; cyc();
    chk("R9 ack clears", {15'd0, match_flag}, 16'h0);
    // R8: one-bit difference is no match
    count = 16'hABCC; #1;
    chk("R8 near miss", {15'd0, match_pulse}, 16'h0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      if (i % 200 == 0) buffered = $urandom_range(0, 1);
      commit_sel = 2'($urandom);
      at_top = ($urandom_range(0, 5) == 0);
      at_bottom = ($urandom_range(0, 5) == 0);
      flag_clr = ($urandom_range(0, 7) == 0);
      irq_ack = ($urandom_range(0, 7) == 0);
      bus_rd_hi = $urandom_range(0, 1);
      count = ($urandom_range(0, 3) == 0) ? m_active : 16'($urandom);
      bus_we = (r < 4); bus_hi = r[0]; bus_wdata = 8'($urandom);
      cyc();
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule